// File: doc/BRIEF.md
# Byte-Wide One-Time-Programmable Memory Model

This block is a clocked, synthesizable stand-in for a byte-wide memory that can be written once. Every cell leaves reset holding 1. A programming write can only pull bits to 0. Five control pins select the operating mode: chip select, output gate, program strobe, a flag for the raised programming supply, and a flag for a raised voltage on address line 9. The modes are read, output off, standby, program, program-verify, program inhibit and identifier read. An identifier read returns a maker byte or a density byte. Both bytes carry odd parity in bit 7.

Three densities are modelled: 8K, 16K and 32K words, chosen by `DENSITY` = 0, 1 or 2. At the largest density the chip-select pin also acts as the program strobe, and the separate strobe pin is ignored. The data bus is split into an input byte, an output byte and an output-drive flag. When the flag is low, the outputs count as high-impedance.

Analog settling is replaced by three cycle counts: address access, chip-select delay and output-gate delay. Only `STORE_AW` low address bits back real storage. Higher address bits alias onto that storage, but every address bit still restarts the access delay.

Top module: `otp_byte_mem`

## Requirements
- R1: After reset every stored byte reads 0xFF, and a byte never programmed keeps reading 0xFF.
- R2: A program cycle replaces the addressed byte with (old AND din). Bits can be cleared but never set again.
- R3: With chip select high at the 8K and 16K densities, whether the supply flag is clear (standby) or set (inhibit), the output-drive flag stays low and no write happens, whatever the output gate does.
- R4: A read (chip select low, output gate low, strobe high, supply flag clear) drives the stored byte. With the chip selected and the output gate high, the output-drive flag is low.
- R5: At the 8K and 16K densities, chip select low, strobe low and supply flag set programs the addressed byte. Chip select low, output gate low, strobe high and supply flag set drives the stored byte as a verify.
- R6: At the 32K density the strobe pin has no effect. With the supply flag set, chip select low and output gate high programs. Chip select high and output gate low verifies. Chip select high and output gate high inhibits.
- R7: With the address-9 flag set in a read, address bit 0 low returns 0x01. Address bit 0 high returns 0x08, 0x89 or 0x04 for density 0, 1 or 2.
- R8: Every identifier byte has an odd number of ones, with bit 7 as the parity bit.
- R9: The output-drive flag rises only after three conditions hold. The address and the address-9 flag must have stayed unchanged for T_ACC clock edges (default 4). The chip must have been selected for T_CE edges (default 4). The output gate must have been low for T_OE edges (default 2).
- R10: An illegal combination causes no write and leaves the output-drive flag low. At the 8K and 16K densities this is the strobe low without the supply flag. At the 32K density it is chip select and output gate both low with the supply flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Model clock |
| rst_n | input | 1 | Active-low reset; restores the erased array |
| ce_n | input | 1 | Chip select, active low (also the program strobe at density 2) |
| oe_n | input | 1 | Output gate, active low |
| pgm_n | input | 1 | Program strobe, active low (ignored at density 2) |
| vpp_hi | input | 1 | Raised programming supply present |
| a9_hv | input | 1 | Raised voltage on address line 9 (identifier read) |
| addr | input | 13+DENSITY | Word address |
| din | input | 8 | Byte to program |
| dout | output | 8 | Byte driven out (0 when not driving) |
| dout_en | output | 1 | Output driven; low means high-impedance |

## Verification
A table of pin patterns walks one address through several stages: erased read, two programming passes, verify, an attempted re-set of cleared bits, standby, output off, an illegal strobe and inhibit. A read after each disturbing pattern separates the case of no write from the case of a wrong write. Identifier patterns flip only address bit 0, which separates the maker byte from the density byte. Further tests move the address, the chip select and the output gate one at a time and sample one edge before and at the edge the output must appear, so each of the three delays is tested on its own. A second instance at the largest density runs the shared-pin program, verify, inhibit and illegal combinations with the strobe pin held low.

// File: rtl/otp_pkg.sv
package otp_pkg;

  typedef enum logic [2:0] {
    MD_STANDBY,
    MD_READ,
    MD_OFF,
    MD_PROG,
    MD_VERIFY,
    MD_INHIBIT,
    MD_IDREAD,
    MD_BAD
  } otp_mode_e;

  localparam logic [7:0] MAKER_CODE = 8'h01;

  function automatic logic [7:0] density_code(input int density);
    case (density)
      0:       return 8'h08;
      1:       return 8'h89;
      default: return 8'h04;
    endcase
  endfunction

  function automatic int density_aw(input int density);
    return 13 + density;
  endfunction

endpackage

// File: rtl/otp_mode_decode.sv
module otp_mode_decode
  import otp_pkg::*;
#(
  parameter int DENSITY = 0
) (
  input  logic      ce_n,
  input  logic      oe_n,
  input  logic      pgm_n,
  input  logic      vpp_hi,
  input  logic      a9_hv,
  output otp_mode_e mode
);

  always_comb begin
    mode = MD_BAD;
    if (DENSITY >= 2) begin
      // shared select/strobe pin
      if (!vpp_hi) begin
        if (ce_n)       mode = MD_STANDBY;
        else if (oe_n)  mode = MD_OFF;
        else if (a9_hv) mode = MD_IDREAD;
        else            mode = MD_READ;
      end else begin
        case ({ce_n, oe_n})
          2'b01:   mode = MD_PROG;
          2'b10:   mode = MD_VERIFY;
          2'b11:   mode = MD_INHIBIT;
          default: mode = MD_BAD;
        endcase
      end
    end else begin
      if (ce_n) begin
        mode = vpp_hi ? MD_INHIBIT : MD_STANDBY;
      end else if (vpp_hi) begin
        if (!pgm_n)     mode = MD_PROG;
        else if (!oe_n) mode = MD_VERIFY;
        else            mode = MD_OFF;
      end else begin
        if (!pgm_n)     mode = MD_BAD;
        else if (oe_n)  mode = MD_OFF;
        else if (a9_hv) mode = MD_IDREAD;
        else            mode = MD_READ;
      end
    end
  end

endmodule

// File: rtl/otp_cell_array.sv
module otp_cell_array #(
  parameter int SAW = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [SAW-1:0] idx,
  input  logic [7:0]     din,
  output logic [7:0]     rdata
);

  localparam int DEPTH = 1 << SAW;

  logic [7:0] cell_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cell_q[i] <= 8'hFF;
    end else if (wr_en) begin
      cell_q[idx] <= cell_q[idx] & din;
    end
  end

  assign rdata = cell_q[idx];

  AST_CLEAR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((cell_q[$past(idx)] & ~$past(rdata)) == 8'h00)); // R2

endmodule

// File: rtl/otp_access_timer.sv
module otp_access_timer #(
  parameter int KW    = 14,
  parameter int T_ACC = 4,
  parameter int T_CE  = 4,
  parameter int T_OE  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [KW-1:0] key,
  input  logic          sel,
  input  logic          oe_act,
  output logic          ready
);

  localparam int TMAX = (T_ACC > T_CE) ? ((T_ACC > T_OE) ? T_ACC : T_OE)
                                       : ((T_CE > T_OE) ? T_CE : T_OE);
  localparam int CW   = $clog2(TMAX + 1);

  logic [KW-1:0] key_q;
  logic          key_new;
  logic [2:0]    live, fresh, met;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) key_q <= '0;
    else        key_q <= key;
  end

  assign key_new = (key != key_q);
  assign live    = {oe_act, sel, 1'b1};
  assign fresh   = {2'b00, key_new};

  for (genvar gi = 0; gi < 3; gi++) begin : g_age
    localparam int LIM = (gi == 0) ? T_ACC : ((gi == 1) ? T_CE : T_OE);
    logic [CW-1:0] age_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   age_q <= '0;
      else if (!live[gi])           age_q <= '0;
      else if (fresh[gi])           age_q <= CW'(1);
      else if (age_q < CW'(TMAX))   age_q <= age_q + CW'(1);
    end

    assign met[gi] = live[gi] && !fresh[gi] && (age_q >= CW'(LIM));
  end

  assign ready = &met;

endmodule

// File: rtl/otp_byte_mem.sv
module otp_byte_mem
  import otp_pkg::*;
#(
  parameter int DENSITY  = 0,
  parameter int STORE_AW = 10,
  parameter int T_ACC    = 4,
  parameter int T_CE     = 4,
  parameter int T_OE     = 2,
  localparam int AW      = density_aw(DENSITY)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          pgm_n,
  input  logic          vpp_hi,
  input  logic          a9_hv,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    din,
  output logic [7:0]    dout,
  output logic          dout_en
);

  localparam logic [7:0] DEV_CODE = density_code(DENSITY);

  otp_mode_e  mode;
  logic       wr_en, sel, data_mode, ready;
  logic [7:0] rdata, id_byte;

  otp_mode_decode #(.DENSITY(DENSITY)) u_decode (
    .ce_n   (ce_n),
    .oe_n   (oe_n),
    .pgm_n  (pgm_n),
    .vpp_hi (vpp_hi),
    .a9_hv  (a9_hv),
    .mode   (mode)
  );

  assign wr_en = (mode == MD_PROG);

  otp_cell_array #(.SAW(STORE_AW)) u_cells (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .idx   (addr[STORE_AW-1:0]),
    .din   (din),
    .rdata (rdata)
  );

  assign sel = !(mode == MD_STANDBY || mode == MD_INHIBIT || mode == MD_BAD);

  otp_access_timer #(
    .KW    (AW + 1),
    .T_ACC (T_ACC),
    .T_CE  (T_CE),
    .T_OE  (T_OE)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .key    ({a9_hv, addr}),
    .sel    (sel),
    .oe_act (!oe_n),
    .ready  (ready)
  );

  assign data_mode = (mode == MD_READ) || (mode == MD_VERIFY) || (mode == MD_IDREAD);
  assign id_byte   = addr[0] ? DEV_CODE : MAKER_CODE;
  assign dout_en   = data_mode && ready;
  assign dout      = !dout_en ? 8'h00 : ((mode == MD_IDREAD) ? id_byte : rdata);

  AST_QUIET_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_STANDBY || mode == MD_INHIBIT) |-> !dout_en); // R3

  AST_ILLEGAL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_BAD) |-> (!dout_en && !wr_en)); // R10

  AST_ID_ODD: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_en && mode == MD_IDREAD) |-> ($countones(dout) % 2 == 1)); // R8

  AST_ADDR_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({a9_hv, addr}) |-> !dout_en); // R9

  AST_OE_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oe_n) |-> !dout_en); // R9

  AST_READ_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_en && $past(dout_en) && $stable(addr) && mode == MD_READ
     && $past(mode) == MD_READ) |-> $stable(dout)); // R4

endmodule

// File: tb/test_otp_byte_mem.sv
module test_otp_byte_mem;

  localparam int AWS = 13;
  localparam int AWL = 15;

  typedef struct packed {
    logic        ce_n;
    logic        oe_n;
    logic        pgm_n;
    logic        vpp;
    logic        a9;
    logic [15:0] addr;
    logic [7:0]  din;
    logic [3:0]  wt;
    logic        en;
    logic [7:0]  dv;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b0,1'b1,1'b0,1'b0,16'h0005,8'h00,4'd5,1'b1,8'hFF,4'd1},  // R1 erased read
    '{1'b0,1'b1,1'b0,1'b1,1'b0,16'h0005,8'hA5,4'd1,1'b0,8'h00,4'd5},  // R5 program A5
    '{1'b0,1'b0,1'b1,1'b1,1'b0,16'h0005,8'h00,4'd5,1'b1,8'hA5,4'd5},  // R5 verify
    '{1'b0,1'b1,1'b0,1'b1,1'b0,16'h0005,8'h0F,4'd1,1'b0,8'h00,4'd2},  // R2 program 0F
    '{1'b0,1'b0,1'b1,1'b0,1'b0,16'h0005,8'h00,4'd5,1'b1,8'h05,4'd2},  // R2 AND result
    '{1'b0,1'b1,1'b0,1'b1,1'b0,16'h0005,8'hFF,4'd1,1'b0,8'h00,4'd2},  // R2 try set bits
    '{1'b0,1'b0,1'b1,1'b0,1'b0,16'h0005,8'h00,4'd5,1'b1,8'h05,4'd2},  // R2 still 05
    '{1'b1,1'b0,1'b1,1'b0,1'b0,16'h0005,8'h00,4'd5,1'b0,8'h00,4'd3},  // R3 standby
    '{1'b0,1'b1,1'b1,1'b0,1'b0,16'h0005,8'h00,4'd5,1'b0,8'h00,4'd4},  // R4 output off
    '{1'b0,1'b1,1'b0,1'b0,1'b0,16'h0005,8'h00,4'd3,1'b0,8'h00,4'd10}, // R10 strobe w/o supply
    '{1'b0,1'b0,1'b1,1'b0,1'b0,16'h0005,8'h00,4'd5,1'b1,8'h05,4'd10}, // R10 no write
    '{1'b1,1'b1,1'b0,1'b1,1'b0,16'h0005,8'h00,4'd3,1'b0,8'h00,4'd3},  // R3 inhibit
    '{1'b0,1'b0,1'b1,1'b0,1'b0,16'h0005,8'h00,4'd5,1'b1,8'h05,4'd3},  // R3 no write
    '{1'b0,1'b0,1'b1,1'b0,1'b1,16'h0000,8'h00,4'd5,1'b1,8'h01,4'd7},  // R7 maker
    '{1'b0,1'b0,1'b1,1'b0,1'b1,16'h0001,8'h00,4'd5,1'b1,8'h08,4'd7},  // R7 density
    '{1'b0,1'b0,1'b1,1'b0,1'b0,16'h0006,8'h00,4'd5,1'b1,8'hFF,4'd1}   // R1 neighbour
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, pgm_n = 1'b1, vpp = 1'b0, a9 = 1'b0;
  logic [AWS-1:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic dout_en;

  logic w_ce_n = 1'b1, w_oe_n = 1'b1, w_pgm_n = 1'b0, w_vpp = 1'b0, w_a9 = 1'b0;
  logic [AWL-1:0] w_addr = '0;
  logic [7:0] w_din = '0;
  logic [7:0] w_dout;
  logic w_dout_en;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  otp_byte_mem i_otp_byte_mem (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .pgm_n(pgm_n),
    .vpp_hi(vpp), .a9_hv(a9), .addr(addr), .din(din),
    .dout(dout), .dout_en(dout_en)
  );

  otp_byte_mem #(.DENSITY(2)) i_otp_byte_mem_wide (
    .clk(clk), .rst_n(rst_n), .ce_n(w_ce_n), .oe_n(w_oe_n), .pgm_n(w_pgm_n),
    .vpp_hi(w_vpp), .a9_hv(w_a9), .addr(w_addr), .din(w_din),
    .dout(w_dout), .dout_en(w_dout_en)
  );

  task automatic chk(input int rq, input logic en_a, input logic en_e,
                     input logic [7:0] d_a, input logic [7:0] d_e);
    n_chk++;
    if (en_a !== en_e || (en_e && d_a !== d_e)) begin
      n_bad++;
      $display("FAIL R%0d: en=%b dout=%02h expected en=%b dout=%02h",
               rq, en_a, d_a, en_e, d_e);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wide(input logic c, input logic o, input logic v,
                      input logic a, input logic [AWL-1:0] ad, input logic [7:0] d);
    @(negedge clk);
    w_ce_n = c; w_oe_n = o; w_vpp = v; w_a9 = a; w_addr = ad; w_din = d;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // reset state: R1/R9 read pins applied, nothing driven in reset
    ce_n = 1'b0; oe_n = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    chk(1, dout_en, 1'b0, dout, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      ce_n = VEC[v].ce_n; oe_n = VEC[v].oe_n; pgm_n = VEC[v].pgm_n;
      vpp = VEC[v].vpp; a9 = VEC[v].a9; addr = VEC[v].addr[AWS-1:0];
      din = VEC[v].din;
      edges(int'(VEC[v].wt));
      chk(int'(VEC[v].rq), dout_en, VEC[v].en, dout, VEC[v].dv);
    end

    // R9 address access: move address, T_ACC=4 edges
    @(negedge clk); ce_n = 0; oe_n = 0; pgm_n = 1; vpp = 0; a9 = 0; addr = 5;
    edges(6);
    @(negedge clk); addr = 6;
    edges(3);
    chk(9, dout_en, 1'b0, dout, 8'h00);
    edges(1);
    chk(9, dout_en, 1'b1, dout, 8'hFF);

    // R9 output gate: T_OE=2 edges
    @(negedge clk); oe_n = 1;
    edges(3);
    @(negedge clk); oe_n = 0;
    edges(1);
    chk(9, dout_en, 1'b0, dout, 8'h00);
    edges(1);
    chk(9, dout_en, 1'b1, dout, 8'hFF);

    // R9 chip select: T_CE=4 edges
    @(negedge clk); ce_n = 1;
    edges(3);
    @(negedge clk); ce_n = 0;
    edges(3);
    chk(9, dout_en, 1'b0, dout, 8'h00);
    edges(1);
    chk(9, dout_en, 1'b1, dout, 8'hFF);

    // R6 wide density, strobe pin held low throughout
    wide(0, 0, 0, 0, 15'd9, 8'h00); edges(5);
    chk(6, w_dout_en, 1'b1, w_dout, 8'hFF);
    wide(0, 1, 1, 0, 15'd9, 8'h3C); edges(1);
    chk(6, w_dout_en, 1'b0, w_dout, 8'h00);
    wide(1, 0, 1, 0, 15'd9, 8'h00); edges(5);
    chk(6, w_dout_en, 1'b1, w_dout, 8'h3C);
    wide(1, 1, 1, 0, 15'd9, 8'h00); edges(2);
    chk(6, w_dout_en, 1'b0, w_dout, 8'h00);
    wide(0, 0, 1, 0, 15'd9, 8'h00); edges(2);
    chk(10, w_dout_en, 1'b0, w_dout, 8'h00);
    wide(0, 0, 0, 0, 15'd9, 8'h00); edges(5);
    chk(10, w_dout_en, 1'b1, w_dout, 8'h3C);
    wide(0, 0, 0, 1, 15'd1, 8'h00); edges(5);
    chk(7, w_dout_en, 1'b1, w_dout, 8'h04);
    wide(0, 0, 0, 1, 15'd0, 8'h00); edges(5);
    chk(8, w_dout_en, 1'b1, w_dout, 8'h01);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule